// File: doc/BRIEF.md
# Amplifier Control Register Slave (I2C write-only)

This block is the control-bus front end for a stereo audio amplifier. It listens on a two-wire I2C bus as a write-only slave. It answers a single fixed device address and stores the settings it receives in a small register file. Those settings appear as parallel outputs: which of four stereo inputs is routed, a 5-bit volume code, and a software mute bit. The SCL and SDA pins are sampled by the system clock. The block pulls SDA low only in acknowledge slots.

A host opens a frame with START and sends the device address. It then sends a sub-address byte and one or more data bytes, and closes with STOP. The sub-address pointer steps forward after every data byte, so one frame can fill both registers. Sub-addresses past the map are acknowledged, but their data goes nowhere. Each register write produces a one-cycle update pulse when the acknowledge of its data byte begins. After power-on reset the outputs are silent: the block is muted and the volume is at its weakest setting, until the host programs it.

Top module: `amp_ctl_i2c`

## Requirements
- R1: After reset, the input select is 0 (input 1), the volume code is 5'b11111, the unmute output is 0 (muted), SDA is not pulled and no update pulse is active.
- R2: When the address byte equals 8'h86 (bit 0 = 0 meaning write), the block pulls SDA low through the ninth SCL high period of that byte and of every later byte of the same frame.
- R3: Any other address byte gets no acknowledge. SDA stays released for the rest of the frame and no register changes.
- R4: A data byte aimed at register 0 loads bits [7:6] into the input select (00 = input 1 through 11 = input 4). Bits [5:0] are ignored. The select update pulse lasts exactly one cycle.
- R5: A data byte aimed at register 1 loads bits [7:3] into the volume code (00000 = most gain, 11111 = least gain) and bit 0 into unmute (0 = muted, 1 = normal). The volume update pulse lasts exactly one cycle.
- R6: After each data byte the pointer advances by one. Sub-address 0 followed by two data bytes writes register 0 and then register 1.
- R7: The pointer saturates above register 1. Data for sub-address 2 or higher, and any data byte after register 1, is acknowledged and then discarded.
- R8: A repeated START aborts the transfer in progress, discards the partial byte, and restarts address reception.
- R9: A STOP in the middle of a byte returns the block to idle, and the registers keep their committed values.
- R10: The SDA pull-down changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| src_sel | output | 2 | Selected stereo input, 0 = input 1 |
| vol_code | output | 5 | Volume code, 0 = most gain |
| unmute | output | 1 | Software mute bit, 0 = muted |
| src_upd | output | 1 | One-cycle pulse when src_sel is written |
| vol_upd | output | 1 | One-cycle pulse when vol_code/unmute are written |

## Verification
The assertions assume that SCL stays at each level for several system clocks. They also assume that SDA moves while SCL is high only to form a START or a STOP, and never while the block is acknowledging. The bench host model meets these assumptions. It changes SDA only a quarter bit after SCL falls and keeps each SCL phase twenty system clocks long. It releases SDA during every acknowledge slot. It forms repeated STARTs by first raising SDA while SCL is still low.

// File: rtl/amp_ctl_pkg.sv
// Shared constants and types for the amplifier control slave.
package amp_ctl_pkg;
    localparam int NUM_REGS = 2;
    localparam int REG_SRC  = 0;
    localparam int REG_VOL  = 1;

    // Position of the byte engine inside a transfer.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BITS,
        PH_ACK,
        PH_SKIP
    } phase_t;

    // What the byte just received means within the frame.
    typedef enum logic [1:0] {
        BK_ADDR,
        BK_SUB,
        BK_DATA
    } bkind_t;
endpackage

// File: rtl/amp_ctl_line_sync.sv
// Brings the asynchronous bus lines into the clock domain through a
// flop chain and reports level, rising edge and falling edge per line.
// Assumes: idle bus level is high; lines are slower than clk.
module amp_ctl_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        // Shift the raw line through the synchroniser and keep one delayed copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~last;
        assign fall[g] = ~chain[STAGES-1] & last;
    end
endmodule

// File: rtl/amp_ctl_byte_engine.sv
// Bit and byte level protocol engine. It finds START and STOP, shifts
// in eight bits MSB first on SCL rising edges, and checks the device
// address. It drives the acknowledge from one SCL fall to the next and
// strobes each accepted byte when its acknowledge begins.
// Assumes: synchronised inputs; SCL phases several clocks long.
module amp_ctl_byte_engine
    import amp_ctl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h86
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    output logic       sda_pull,
    output logic       byte_stb,
    output bkind_t     byte_kind,
    output logic [7:0] byte_data
);
    localparam int CNT_W = $clog2(9);

    phase_t            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [7:0]        shreg;
    logic              start_det;
    logic              stop_det;

    // Bus conditions: SDA moving while SCL is high.
    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;

    // Frame sequencing, shifting, address match and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            byte_kind <= BK_ADDR;
            sda_pull  <= 1'b0;
            byte_stb  <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (start_det) begin
                phase     <= PH_BITS;
                bitcnt    <= '0;
                byte_kind <= BK_ADDR;
                sda_pull  <= 1'b0;
            end else if (stop_det) begin
                phase    <= PH_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (phase)
                    PH_BITS: begin
                        if (scl_rise && bitcnt != CNT_W'(8)) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_W'(8)) begin
                            if (byte_kind == BK_ADDR && shreg != DEV_ADDR) begin
                                phase <= PH_SKIP;
                            end else begin
                                phase    <= PH_ACK;
                                sda_pull <= 1'b1;
                                byte_stb <= 1'b1;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            sda_pull  <= 1'b0;
                            phase     <= PH_BITS;
                            bitcnt    <= '0;
                            byte_kind <= (byte_kind == BK_ADDR) ? BK_SUB : BK_DATA;
                        end
                    end
                    default: begin
                        phase <= phase;
                    end
                endcase
            end
        end
    end

    assign byte_data = shreg;
endmodule

// File: rtl/amp_ctl_regfile.sv
// Control register file behind the bus engine. It holds a saturating
// sub-address pointer, the input select, volume and mute fields, and
// raises one update pulse for each register written.
// Assumes: byte_stb is a single-cycle strobe with byte_data stable.
module amp_ctl_regfile
    import amp_ctl_pkg::*;
#(
    parameter int SRC_W = 2,
    parameter int VOL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_stb,
    input  bkind_t           byte_kind,
    input  logic [7:0]       byte_data,
    output logic [SRC_W-1:0] src_sel,
    output logic [VOL_W-1:0] vol_code,
    output logic             unmute,
    output logic             src_upd,
    output logic             vol_upd
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

    logic [PTR_W-1:0] ptr;

    // Pointer load on sub-address, saturating advance on data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (byte_stb && byte_kind == BK_SUB) begin
            ptr <= (byte_data >= 8'(NUM_REGS)) ? PTR_END : byte_data[PTR_W-1:0];
        end else if (byte_stb && byte_kind == BK_DATA && ptr != PTR_END) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Field writes with silent defaults and per-register update pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel  <= '0;
            vol_code <= '1;
            unmute   <= 1'b0;
            src_upd  <= 1'b0;
            vol_upd  <= 1'b0;
        end else begin
            src_upd <= 1'b0;
            vol_upd <= 1'b0;
            if (byte_stb && byte_kind == BK_DATA) begin
                if (ptr == PTR_W'(REG_SRC)) begin
                    src_sel <= byte_data[7 -: SRC_W];
                    src_upd <= 1'b1;
                end else if (ptr == PTR_W'(REG_VOL)) begin
                    vol_code <= byte_data[7 -: VOL_W];
                    unmute   <= byte_data[0];
                    vol_upd  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/amp_ctl_i2c.sv
// Top of the amplifier control slave: synchroniser, byte engine and
// register file. It is write-only with a fixed device address.
// Assumes: external open-drain pad turns sda_pull into an SDA low.
module amp_ctl_i2c
    import amp_ctl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DEV_ADDR    = 8'h86,
    parameter int         SRC_W       = 2,
    parameter int         VOL_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull,
    output logic [SRC_W-1:0] src_sel,
    output logic [VOL_W-1:0] vol_code,
    output logic             unmute,
    output logic             src_upd,
    output logic             vol_upd
);
    logic [1:0] lvl, rise, fall;
    logic       scl_s;
    logic       byte_stb;
    bkind_t     byte_kind;
    logic [7:0] byte_data;

    amp_ctl_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_in, scl_in}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign scl_s = lvl[0];

    amp_ctl_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_s),
        .scl_rise (rise[0]),
        .scl_fall (fall[0]),
        .sda_lvl  (lvl[1]),
        .sda_rise (rise[1]),
        .sda_fall (fall[1]),
        .sda_pull (sda_pull),
        .byte_stb (byte_stb),
        .byte_kind(byte_kind),
        .byte_data(byte_data)
    );

    amp_ctl_regfile #(.SRC_W(SRC_W), .VOL_W(VOL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_stb (byte_stb),
        .byte_kind(byte_kind),
        .byte_data(byte_data),
        .src_sel  (src_sel),
        .vol_code (vol_code),
        .unmute   (unmute),
        .src_upd  (src_upd),
        .vol_upd  (vol_upd)
    );
endmodule

// File: rtl/amp_ctl_i2c_chk.sv
// Property checker for amp_ctl_i2c, attached by bind.
// Assumes: legal bus stimulus (no START/STOP during an acknowledge).
module amp_ctl_i2c_chk #(
    parameter int SRC_W = 2,
    parameter int VOL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_pull,
    input logic [SRC_W-1:0] src_sel,
    input logic [VOL_W-1:0] vol_code,
    input logic             unmute,
    input logic             src_upd,
    input logic             vol_upd
);
    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    assert_src_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src_upd |=> !src_upd);

    assert_src_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel != $past(src_sel)) |-> src_upd);

    assert_vol_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vol_upd |=> !vol_upd);

    assert_vol_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((vol_code != $past(vol_code)) || (unmute != $past(unmute))) |-> vol_upd);

    assert_one_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_upd, vol_upd}));
endmodule

bind amp_ctl_i2c amp_ctl_i2c_chk #(.SRC_W(SRC_W), .VOL_W(VOL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_pull(sda_pull),
    .src_sel (src_sel),
    .vol_code(vol_code),
    .unmute  (unmute),
    .src_upd (src_upd),
    .vol_upd (vol_upd)
);

// File: tb/amp_ctl_i2c_tb.sv
module amp_ctl_i2c_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_pull, unmute, src_upd, vol_upd;
    logic [1:0] src_sel;
    logic [4:0] vol_code;
    wire  sda_bus = host_sda & ~sda_pull;

    int checks = 0;
    int fails = 0;
    int src_cnt = 0;
    int vol_cnt = 0;
    logic [1:0] exp_src = 2'd0;
    logic [4:0] exp_vol = 5'h1f;
    logic       exp_un = 1'b0;
    int exp_src_cnt = 0;
    int exp_vol_cnt = 0;
    logic [7:0] dq [4];

    always #5 clk = ~clk;

    amp_ctl_i2c u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .src_sel(src_sel), .vol_code(vol_code),
        .unmute(unmute), .src_upd(src_upd), .vol_upd(vol_upd)
    );

    always @(posedge clk) begin
        if (src_upd) src_cnt <= src_cnt + 1;
        if (vol_upd) vol_cnt <= vol_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic q_wait(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; q_wait(1);
        host_scl = 1'b1; q_wait(1);
        host_sda = 1'b0; q_wait(1);
        host_scl = 1'b0; q_wait(1);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; q_wait(1);
        host_scl = 1'b1; q_wait(1);
        host_sda = 1'b1; q_wait(1);
    endtask

    task automatic send_bit(input logic b);
        host_sda = b;    q_wait(1);
        host_scl = 1'b1; q_wait(2);
        host_scl = 1'b0; q_wait(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        host_sda = 1'b1; q_wait(1);
        host_scl = 1'b1; q_wait(1);
        ack = sda_pull;  q_wait(1);
        host_scl = 1'b0; q_wait(1);
    endtask

    // Reference model of one accepted write frame.
    task automatic model(input logic [7:0] sub, input int n);
        int p;
        p = (sub >= 8'd2) ? 2 : int'(sub);
        for (int i = 0; i < n; i++) begin
            if (p == 0) begin
                exp_src = dq[i][7:6]; exp_src_cnt++;
            end else if (p == 1) begin
                exp_vol = dq[i][7:3]; exp_un = dq[i][0]; exp_vol_cnt++;
            end
            if (p < 2) p++;
        end
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " src_sel"}, src_sel, exp_src);
        chk({tag, " vol_code"}, vol_code, exp_vol);
        chk({tag, " unmute"}, unmute, exp_un);
        chk({tag, " src_upd count"}, src_cnt, exp_src_cnt);
        chk({tag, " vol_upd count"}, vol_cnt, exp_vol_cnt);
    endtask

    task automatic tx(input logic [7:0] addr, input logic [7:0] sub, input int n,
                      input string tag);
        logic ack;
        logic hit;
        hit = (addr == 8'h86);
        bus_start();
        send_byte(addr, ack);
        chk(hit ? "R2 address ack" : "R3 address nack", ack, hit);
        send_byte(sub, ack);
        chk(hit ? "R2 sub ack" : "R3 sub nack", ack, hit);
        for (int i = 0; i < n; i++) begin
            send_byte(dq[i], ack);
            chk((hit && sub > 8'd1) ? "R7 discarded data ack" :
                (hit ? "R2 data ack" : "R3 data nack"), ack, hit);
        end
        bus_stop();
        q_wait(1);
        if (hit) model(sub, n);
        check_regs(tag);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
        $finish;
    end

    initial begin : main
        logic ack;
        logic [7:0] sub;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 src_sel", src_sel, 0);
        chk("R1 vol_code", vol_code, 31);
        chk("R1 unmute", unmute, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 upd pulses", src_cnt + vol_cnt, 0);

        // R4 input select, low bits ignored
        dq[0] = 8'hBF; tx(8'h86, 8'h00, 1, "R4");
        // R5 volume and mute
        dq[0] = 8'h41; tx(8'h86, 8'h01, 1, "R5");
        // R6 auto-increment across both registers
        dq[0] = 8'hC0; dq[1] = 8'h98; tx(8'h86, 8'h00, 2, "R6");
        // R7 saturation past register 1 and out-of-map sub-address
        dq[0] = 8'h40; dq[1] = 8'h51; dq[2] = 8'h00; tx(8'h86, 8'h00, 3, "R7");
        dq[0] = 8'hFF; tx(8'h86, 8'h07, 1, "R7 sub 7");
        // R3 wrong addresses, including read direction
        dq[0] = 8'h00; tx(8'h84, 8'h01, 1, "R3");
        dq[0] = 8'h00; tx(8'h87, 8'h00, 1, "R3 read bit");

        // R9 stop in the middle of a data byte
        bus_start();
        send_byte(8'h86, ack);
        send_byte(8'h01, ack);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        bus_stop();
        q_wait(1);
        check_regs("R9");

        // R8 repeated start aborts partial byte
        bus_start();
        send_byte(8'h86, ack);
        send_byte(8'h01, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_start();
        send_byte(8'h86, ack);
        chk("R8 address ack after restart", ack, 1);
        send_byte(8'h00, ack);
        send_byte(8'h80, ack);
        bus_stop();
        q_wait(1);
        dq[0] = 8'h80; model(8'h00, 1);
        check_regs("R8");

        // Random frames (R2 R4 R5 R6 R7)
        for (int t = 0; t < 30; t++) begin
            int n;
            int pick;
            logic [7:0] addr;
            pick = int'($urandom_range(0, 9));
            addr = (pick == 0) ? 8'($urandom_range(0, 255)) : 8'h86;
            pick = int'($urandom_range(0, 3));
            sub  = (pick == 3) ? 8'($urandom_range(0, 255)) : 8'(pick);
            n    = int'($urandom_range(1, 3));
            for (int i = 0; i < 4; i++) dq[i] = 8'($urandom_range(0, 255));
            tx(addr, sub, n, "R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule